// File: doc/BRIEF.md
# Self-Clocked Line Decoder (Biphase Mark / Manchester)

This block recovers a serial bit stream from one self-clocked wire. Two line codes are supported and chosen with a mode input. In biphase mark coding every bit cell begins with a transition, and a logic 1 adds a second transition half way through the cell. In Manchester coding every cell has a transition in its middle: low-to-high carries a 1 and high-to-low carries a 0. Transitions at cell boundaries occur only when two neighbouring bits are equal.

The decoder has no phase-locked loop and does no oversampled clock recovery. The line is synchronised and compared with its value one clock earlier. Either direction of change counts as an edge. A gate timer runs for three quarters of a bit period, and the bit period in system clocks is a parameter. In biphase mode the gate is a window opened by each cell's leading edge, and an edge inside the window marks a 1. In Manchester mode the gate is a hold-off that hides the boundary edges following an accepted mid-cell edge. A silence timer of one and a half bit periods flags loss of signal, and decoding restarts on the next edge.

Each decoded bit appears on a data output together with a one-clock valid strobe. The data output holds its value between strobes.

Top module: `selfclk_line_decoder`

## Requirements
- R1: While reset is asserted, and after its release until the first line edge, `bit_o`, `bit_vld_o` and `los_o` are all 0.
- R2: Any change of the synchronised line level counts as an edge, whether it rises or falls.
- R3: In biphase mode (`mode_i` = 0), an edge seen while the gate is idle starts a cell and opens a window of 3/4 bit period. The cell decodes as 1 if another edge arrives inside the window and as 0 otherwise. Its strobe comes 3 + 3·BIT_CLKS/4 clocks after the line change that started the cell.
- R4: In Manchester mode (`mode_i` = 1), an edge seen while the gate is idle is accepted and starts a hold-off of 3/4 bit period. The new line level becomes the bit (rising gives 1, falling gives 0). Edges during the hold-off produce no bit.
- R5: In Manchester mode the strobe for an accepted edge is high during the third clock after the line change.
- R6: `bit_vld_o` is one clock wide and pulses exactly once per transmitted bit cell.
- R7: If no edge arrives for 3·BIT_CLKS/2 clocks, `los_o` rises. It stays high until the next edge and is never raised while edges keep coming within one bit period.
- R8: After reset or loss of signal, the first edge is taken as a cell start in biphase mode and as a mid-cell edge in Manchester mode, and decoding resumes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous coded serial line |
| mode_i | input | 1 | 0 = biphase mark, 1 = Manchester |
| bit_o | output | 1 | Last decoded data bit |
| bit_vld_o | output | 1 | One-clock strobe for each decoded bit |
| los_o | output | 1 | Loss of signal; cleared by the next edge |

## Verification
Biphase streams are sent as all zeros, all ones and random data. All zeros never opens a mid-cell edge inside the window, and all ones always does, so these separate the window decision from the boundary retrigger. Manchester streams are sent as alternating bits, which have no boundary edges and so test acceptance at full-period spacing, as runs of equal bits, which have a boundary edge in every cell that the hold-off must hide, and as random data. Mid-cell edges are jittered by one clock, bursts are split by silences that must raise loss of signal, and each new burst checks resynchronisation on its first edge.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic {
    CODE_BIPHASE = 1'b0,
    CODE_MANCH   = 1'b1
  } line_code_e;
endpackage

// File: rtl/lcd_line_sync.sv
module lcd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic edge_p
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_n[g] = line_i;
      end else begin : g_next
        assign sync_n[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_s = sync_q[STAGES-1];
  assign edge_p = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lcd_pulse_timer.sv
module lcd_pulse_timer #(
  parameter int LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic expire
);
  localparam int W = $clog2(LEN + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (fire) begin
      cnt_n = W'(LEN);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/selfclk_line_decoder.sv
module selfclk_line_decoder
  import lcd_pkg::*;
#(
  parameter int BIT_CLKS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic mode_i,
  output logic bit_o,
  output logic bit_vld_o,
  output logic los_o
);
  localparam int GATE_CLKS = (3 * BIT_CLKS) / 4;
  localparam int LOS_CLKS  = (3 * BIT_CLKS) / 2;

  line_code_e code;
  logic line_s;
  logic edge_p;
  logic gate_fire;
  logic gate_busy;
  logic gate_exp;
  logic los_exp;

  logic mid_q, mid_n;
  logic bit_q, bit_n;
  logic vld_q, vld_n;
  logic los_q, los_n;

  assign code = line_code_e'(mode_i);

  lcd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .line_s (line_s),
    .edge_p (edge_p)
  );

  // window (biphase) or hold-off (Manchester): one timer, modes exclusive
  assign gate_fire = edge_p & ~gate_busy;

  lcd_pulse_timer #(.LEN(GATE_CLKS)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (gate_fire),
    .busy   (gate_busy),
    .expire (gate_exp)
  );

  lcd_pulse_timer #(.LEN(LOS_CLKS)) u_quiet (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (edge_p),
    .busy   (),
    .expire (los_exp)
  );

  always_comb begin
    mid_n = mid_q;
    bit_n = bit_q;
    vld_n = 1'b0;
    los_n = los_q;
    unique case (code)
      CODE_BIPHASE: begin
        if (gate_fire) begin
          mid_n = 1'b0;
        end else if (edge_p) begin
          mid_n = 1'b1;
        end
        if (gate_exp) begin
          vld_n = 1'b1;
          bit_n = mid_q | edge_p;
        end
      end
      CODE_MANCH: begin
        if (gate_fire) begin
          vld_n = 1'b1;
          bit_n = line_s;
        end
      end
      default: ;
    endcase
    if (edge_p) begin
      los_n = 1'b0;
    end else if (los_exp) begin
      los_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
      los_q <= 1'b0;
    end else begin
      mid_q <= mid_n;
      bit_q <= bit_n;
      vld_q <= vld_n;
      los_q <= los_n;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
  assign los_o     = los_q;
endmodule

// File: rtl/selfclk_line_decoder_chk.sv
module selfclk_line_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_i,
  input logic edge_p,
  input logic vld,
  input logic los,
  input logic bit_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!vld && !los && !bit_q);
    end
  end

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  assert_manch_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && $past(mode_i)) |-> $past(edge_p));

  assert_los_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_p |=> !los);

  assert_los_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !edge_p) |=> los);

  assert_los_after_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> !$past(edge_p));
endmodule

bind selfclk_line_decoder selfclk_line_decoder_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_i (mode_i),
  .edge_p (edge_p),
  .vld    (bit_vld_o),
  .los    (los_o),
  .bit_q  (bit_o)
);

// File: tb/tb_selfclk_line_decoder.sv
module tb_selfclk_line_decoder;
  localparam int BIT    = 16;
  localparam int HALF   = BIT / 2;
  localparam int GATE   = (3 * BIT) / 4;
  localparam int TCLK   = 8;
  localparam int MAXB   = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic line;
  logic mode;
  logic bit_o, bit_vld_o, los_o;

  int checks = 0;
  int fails  = 0;
  logic exp_bits [0:MAXB-1];
  int wr_idx = 0;
  int rd_idx = 0;
  bit started = 0;
  bit prev_vld = 0;
  longint last_chg_t = 0;
  longint cell_t = 0;

  always #(TCLK/2) clk = ~clk;

  selfclk_line_decoder #(.BIT_CLKS(BIT)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_i    (line),
    .mode_i    (mode),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o),
    .los_o     (los_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // pattern: 0 random, 1 zeros, 2 ones, 3 alternating
  function automatic logic pick_bit(input int kind, input int idx, input logic prev);
    case (kind)
      1:       return 1'b0;
      2:       return 1'b1;
      3:       return (idx == 0) ? 1'b0 : ~prev;
      default: return logic'($urandom & 1);
    endcase
  endfunction

  // called at a negedge; leaves at a negedge
  task automatic seg(input logic v, input int n);
    if (v !== line) begin
      line = v;
      last_chg_t = $time;
    end
    repeat (n) @(negedge clk);
  endtask

  // monitor: value, width and latency of every strobe (R2..R6)
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (bit_vld_o) begin
        if (rd_idx < wr_idx) begin
          chk(bit_o === exp_bits[rd_idx], mode ? "R4 manchester bit" : "R3 biphase bit",
              bit_o, exp_bits[rd_idx]);
        end else begin
          chk(1'b0, "R6 unexpected strobe", rd_idx, wr_idx);
        end
        rd_idx++;
        chk(!prev_vld, "R6 strobe width", 2, 1);
        if (mode) begin
          chk(($time - last_chg_t) == 3 * TCLK, "R5 manchester latency",
              ($time - last_chg_t) / TCLK, 3);
        end else begin
          chk(($time - cell_t) == (3 + GATE) * TCLK, "R3 biphase latency",
              ($time - cell_t) / TCLK, 3 + GATE);
        end
      end
      prev_vld = bit_vld_o;
    end
  end

  task automatic burst(input logic m, input int n, input int kind, input bit jitter);
    logic b;
    logic prev;
    int h1;
    mode = m;
    repeat (2) @(negedge clk);
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      b = pick_bit(kind, i, prev);
      if (m && i == 0) b = ~line;  // R8: first edge is the mid-cell edge
      prev = b;
      exp_bits[wr_idx] = b;
      wr_idx++;
      h1 = HALF;
      if (jitter) h1 = HALF - 1 + int'($urandom % 3);
      if (!m) begin
        cell_t = $time;
        seg(~line, h1);               // R2: both directions used
        if (b) seg(~line, BIT - h1);
        else   seg(line, BIT - h1);
      end else begin
        seg(~b, h1);
        seg(b, BIT - h1);
      end
      if (i > 0) chk(los_o == 1'b0, "R7 no loss while active / R8 resync", los_o, 0);
    end
    repeat (BIT * 5 / 2) @(negedge clk);
    chk(rd_idx == wr_idx, "R6 one strobe per bit", rd_idx, wr_idx);
    rd_idx = wr_idx;
    chk(los_o == 1'b1, "R7 loss after silence", los_o, 1);
  endtask

  initial begin
    #(200000 * TCLK);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C0D));
    rst_n = 1'b0;
    line  = 1'b0;
    mode  = 1'b0;
    repeat (3) @(negedge clk);
    chk({bit_o, bit_vld_o, los_o} == 3'b000, "R1 reset state", {bit_o, bit_vld_o, los_o}, 0);
    rst_n = 1'b1;
    repeat (BIT * 3) @(negedge clk);
    chk({bit_o, bit_vld_o, los_o} == 3'b000, "R1 idle after reset", {bit_o, bit_vld_o, los_o}, 0);
    started = 1;

    burst(1'b0, 12, 1, 1'b0);
    burst(1'b0, 12, 2, 1'b1);
    burst(1'b0, 24, 0, 1'b1);
    burst(1'b1, 12, 3, 1'b0);
    burst(1'b1, 12, 1, 1'b1);
    burst(1'b1, 12, 2, 1'b0);
    burst(1'b1, 24, 0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      burst(logic'($urandom & 1), 16 + int'($urandom % 16), 0, 1'b1);
    end
    started = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule